// File: doc/BRIEF.md
# Safety Error Status Aggregator

This block gathers single-cycle error pulses from three protected regions of a network controller: the MAC datapath and its state machines, the transmit/receive queue memories, and the DMA segmentation-offload memory. Each region has a 32-bit status word. A bit in that word is set by a pulse on its defined source and stays set until software writes a one to it. From the three status words the block forms correctable and uncorrectable summary flags. These drive interrupt lines toward the system interrupt controller.

Software reads and writes the block through a small register port. A write takes effect at the clock edge where it is presented. A read returns its data one cycle later. Enable registers control which correctable sources may raise the correctable interrupt. Uncorrectable conditions always interrupt. Every MAC-region error counts as uncorrectable, and its summary appears in both summary registers. The queue-memory summaries are also copied into the DMA summary register.

Top module: `safety_err_agg`

## Requirements
- R1: The MAC status word (address 0) latches pulses only on bits 0 to 19 and bit 24; every other bit of it always reads zero.
- R2: The queue-memory status word (address 1) holds four groups of three bits at bit offsets 0 (transmit), 4 (receive), 8 (scheduling table) and 12 (receive parser). Each group holds a correctable error at +0, an address mismatch at +1 and an uncorrectable error at +2. All other bits read zero.
- R3: The DMA status word (address 2) latches only bits 0 (correctable), 1 (address mismatch) and 2 (uncorrectable); other bits read zero.
- R4: A status bit stays set until a write to its address carries a one in that position; writing zero to a bit leaves it unchanged.
- R5: When an error pulse arrives in the same cycle as a clearing write to the same bit, the bit stays set.
- R6: The queue summary register (address 3, read only) shows bit 0 = any queue correctable bit, bit 1 = any queue mismatch or uncorrectable bit, and bit 2 = any MAC bit. Its other bits are zero, and writes to it are ignored.
- R7: The DMA summary register (address 4, read only) shows bit 0 = DMA correctable, bit 1 = DMA mismatch or uncorrectable, bit 2 = queue correctable summary, bit 3 = queue uncorrectable summary, and bit 4 = MAC summary.
- R8: Address 5 bits 0 to 3 enable the correctable interrupt for the transmit, receive, scheduling-table and parser memories. Address 6 bit 0 enables it for the DMA memory. Both registers read back what was written. corr_irq is high exactly when some correctable status bit is set and its enable is set.
- R9: uncorr_irq is high whenever any MAC bit, any queue mismatch or uncorrectable bit, or DMA bit 1 or 2 is set, whatever the enables.
- R10: err_irq equals corr_irq OR uncorr_irq.
- R11: A read request gives rd_valid high for one cycle on the following cycle, with the addressed word on rd_data. Address 7 reads zero.
- R12: Synchronous active-high reset clears all status words and enables, so every register reads zero and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_err_i | input | 32 | MAC region error pulses |
| mtl_err_i | input | 32 | Queue-memory error pulses |
| dma_err_i | input | 32 | DMA memory error pulses |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register word address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| corr_irq | output | 1 | Enabled correctable error pending |
| uncorr_irq | output | 1 | Uncorrectable error pending |
| err_irq | output | 1 | Any interrupt pending |

## Verification
Two things can hit the same status bit in one cycle: a new error pulse and a software write that clears that bit. The bench presents a pulse on a queue-memory mismatch bit in the same cycle as a write carrying a one in that position. It then reads the word back and expects the bit still set. In the same bench, interrupt enables are changed while a correctable bit stays latched. This shows that corr_irq follows the enable immediately while the status word is left as it was.

// File: rtl/safe_err_pkg.sv
package safe_err_pkg;

    localparam int DW    = 32;
    localparam int AW    = 3;
    localparam int NBANK = 3;
    localparam int NMEM  = 4;
    localparam int GRP   = 4;

    localparam logic [DW-1:0] MAC_MASK      = 32'h010F_FFFF;
    localparam logic [DW-1:0] MTL_MASK      = 32'h0000_7777;
    localparam logic [DW-1:0] DMA_MASK      = 32'h0000_0007;
    localparam logic [DW-1:0] MTL_CORR_MASK = 32'h0000_1111;
    localparam logic [DW-1:0] DMA_CORR_MASK = 32'h0000_0001;

    typedef enum logic [AW-1:0] {
        A_MAC    = 3'd0,
        A_MTL    = 3'd1,
        A_DMA    = 3'd2,
        A_MTLSUM = 3'd3,
        A_DMASUM = 3'd4,
        A_MTLEN  = 3'd5,
        A_DMAEN  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic mac;
        logic mtl_unc;
        logic mtl_cor;
        logic dma_unc;
        logic dma_cor;
    } sum_t;

    function automatic logic [DW-1:0] bank_mask(input int idx);
        case (idx)
            0:       return MAC_MASK;
            1:       return MTL_MASK;
            default: return DMA_MASK;
        endcase
    endfunction

    // Place one enable bit per memory at the correctable slot of its group.
    function automatic logic [DW-1:0] spread_en(input logic [NMEM-1:0] en);
        logic [DW-1:0] v;
        v = '0;
        for (int k = 0; k < NMEM; k++) v[k*GRP] = en[k];
        return v;
    endfunction

endpackage

// File: rtl/safe_err_bank.sv
module safe_err_bank
    import safe_err_pkg::*;
#(
    parameter logic [DW-1:0] MASK = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] pulse_i,
    input  logic [DW-1:0] clr_i,
    output logic [DW-1:0] status_o
);

    logic [DW-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= ((status_q & ~clr_i) | pulse_i) & MASK;
    end

    assign status_o = status_q;

    // R1 R2 R3: only defined positions can ever hold a one
    p_undef_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (status_q & ~MASK) == '0);

    // R4: a set bit stays set unless a clear arrived
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (($past(status_q) & ~$past(clr_i)) & ~status_q) == '0);

    // R4: a cleared bit with no new pulse is zero afterwards
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (($past(clr_i) & ~$past(pulse_i)) & status_q) == '0);

    // R5: a defined pulse always lands, even against a clear
    p_pulse_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (($past(pulse_i) & MASK) & ~status_q) == '0);

endmodule

// File: rtl/safe_err_summary.sv
module safe_err_summary
    import safe_err_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   mac_st,
    input  logic [DW-1:0]   mtl_st,
    input  logic [DW-1:0]   dma_st,
    input  logic [NMEM-1:0] mtl_en,
    input  logic            dma_en,
    output sum_t            sum_o,
    output logic            corr_irq,
    output logic            uncorr_irq,
    output logic            err_irq
);

    logic [DW-1:0] mtl_gate;

    always_comb begin
        sum_o.mac     = |mac_st;
        sum_o.mtl_cor = |(mtl_st & MTL_CORR_MASK);
        sum_o.mtl_unc = |(mtl_st & MTL_MASK & ~MTL_CORR_MASK);
        sum_o.dma_cor = |(dma_st & DMA_CORR_MASK);
        sum_o.dma_unc = |(dma_st & DMA_MASK & ~DMA_CORR_MASK);
        mtl_gate      = spread_en(mtl_en);
    end

    assign corr_irq   = (|(mtl_st & MTL_CORR_MASK & mtl_gate)) |
                        (|(dma_st & DMA_CORR_MASK) & dma_en);
    assign uncorr_irq = sum_o.mac | sum_o.mtl_unc | sum_o.dma_unc;
    assign err_irq    = corr_irq | uncorr_irq;

    // R9: any MAC error must raise the uncorrectable line
    p_mac_uncorr_r9: assert property (@(posedge clk) disable iff (rst)
        (|mac_st) |-> uncorr_irq);

    // R8: with all enables low the correctable line stays quiet
    p_no_en_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (mtl_en == '0 && !dma_en) |-> !corr_irq);

endmodule

// File: rtl/safe_err_regif.sv
module safe_err_regif
    import safe_err_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [AW-1:0]              req_addr,
    input  logic [DW-1:0]              req_wdata,
    input  logic [NBANK-1:0][DW-1:0]   status_i,
    input  sum_t                       sum_i,
    output logic [NBANK-1:0][DW-1:0]   clr_o,
    output logic [NMEM-1:0]            mtl_en_o,
    output logic                       dma_en_o,
    output logic                       rd_valid,
    output logic [DW-1:0]              rd_data
);

    logic          wr, rd;
    logic [DW-1:0] rd_mux;

    assign wr = req_valid &  req_write;
    assign rd = req_valid & ~req_write;

    for (genvar g = 0; g < NBANK; g++) begin : g_clr
        assign clr_o[g] = (wr && req_addr == AW'(g)) ? req_wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mtl_en_o <= '0;
            dma_en_o <= 1'b0;
        end else if (wr) begin
            if (req_addr == A_MTLEN) mtl_en_o <= req_wdata[NMEM-1:0];
            if (req_addr == A_DMAEN) dma_en_o <= req_wdata[0];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (req_addr)
            A_MAC:    rd_mux = status_i[0];
            A_MTL:    rd_mux = status_i[1];
            A_DMA:    rd_mux = status_i[2];
            A_MTLSUM: rd_mux = {{(DW-3){1'b0}}, sum_i.mac, sum_i.mtl_unc, sum_i.mtl_cor};
            A_DMASUM: rd_mux = {{(DW-5){1'b0}}, sum_i};
            A_MTLEN:  rd_mux = {{(DW-NMEM){1'b0}}, mtl_en_o};
            A_DMAEN:  rd_mux = {{(DW-1){1'b0}}, dma_en_o};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd;
            if (rd) rd_data <= rd_mux;
        end
    end

    // R11: read data valid exactly one cycle after a read request
    p_rd_latency_r11: assert property (@(posedge clk) disable iff (rst)
        rd |=> rd_valid);
    p_rd_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rd_valid);

endmodule

// File: rtl/safety_err_agg.sv
module safety_err_agg
    import safe_err_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   mac_err_i,
    input  logic [31:0]   mtl_err_i,
    input  logic [31:0]   dma_err_i,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [2:0]    req_addr,
    input  logic [31:0]   req_wdata,
    output logic          rd_valid,
    output logic [31:0]   rd_data,
    output logic          corr_irq,
    output logic          uncorr_irq,
    output logic          err_irq
);

    logic [NBANK-1:0][DW-1:0] pulse_all, clr_all, stat_all;
    logic [NMEM-1:0]          mtl_en;
    logic                     dma_en;
    sum_t                     sum;

    assign pulse_all = {dma_err_i, mtl_err_i, mac_err_i};

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        safe_err_bank #(.MASK(bank_mask(g))) u_bank (
            .clk      (clk),
            .rst      (rst),
            .pulse_i  (pulse_all[g]),
            .clr_i    (clr_all[g]),
            .status_o (stat_all[g])
        );
    end

    safe_err_summary u_sum (
        .clk        (clk),
        .rst        (rst),
        .mac_st     (stat_all[0]),
        .mtl_st     (stat_all[1]),
        .dma_st     (stat_all[2]),
        .mtl_en     (mtl_en),
        .dma_en     (dma_en),
        .sum_o      (sum),
        .corr_irq   (corr_irq),
        .uncorr_irq (uncorr_irq),
        .err_irq    (err_irq)
    );

    safe_err_regif u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .status_i  (stat_all),
        .sum_i     (sum),
        .clr_o     (clr_all),
        .mtl_en_o  (mtl_en),
        .dma_en_o  (dma_en),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/safety_err_agg_tb.sv
`timescale 1ns/1ps
module safety_err_agg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mac_err_i = '0, mtl_err_i = '0, dma_err_i = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid, corr_irq, uncorr_irq, err_irq;
    logic [31:0] rd_data;

    int n_run = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    safety_err_agg u_dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) chk("R11 unexpected read", 32'h1, 32'h0);
            else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic pulse(logic [31:0] m, logic [31:0] q, logic [31:0] d);
        mac_err_i = m; mtl_err_i = q; dma_err_i = d;
        @(negedge clk);
        mac_err_i = '0; mtl_err_i = '0; dma_err_i = '0;
    endtask

    task automatic irqs(logic c, logic u, string tag);
        chk({tag, " corr_irq"}, {31'b0, corr_irq}, {31'b0, c});
        chk({tag, " uncorr_irq"}, {31'b0, uncorr_irq}, {31'b0, u});
        chk("R10 err_irq", {31'b0, err_irq}, {31'b0, c | u});
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        for (int a = 0; a < 7; a++) rd(3'(a), 32'h0, "R12 reset read");
        irqs(1'b0, 1'b0, "R12");

        // R1 MAC bank, R9 uncorrectable, R6/R7 summaries
        pulse(32'hFFFF_FFFF, '0, '0);
        rd(3'd0, 32'h010F_FFFF, "R1 mac mask");
        rd(3'd3, 32'h4, "R6 mac in queue summary");
        rd(3'd4, 32'h10, "R7 mac in dma summary");
        irqs(1'b0, 1'b1, "R9 mac");
        wr(3'd0, 32'h0);
        rd(3'd0, 32'h010F_FFFF, "R4 zero write keeps");
        wr(3'd0, 32'h0000_0001);
        rd(3'd0, 32'h010F_FFFE, "R4 single clear");
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, 32'h0, "R4 full clear");
        irqs(1'b0, 1'b0, "R4 after clear");

        // R2 queue bank
        pulse('0, 32'hFFFF_FFFF, '0);
        rd(3'd1, 32'h0000_7777, "R2 queue mask");
        rd(3'd3, 32'h3, "R6 queue summary");
        rd(3'd4, 32'hC, "R7 queue mirror");
        irqs(1'b0, 1'b1, "R9 queue");
        wr(3'd1, 32'hFFFF_FFFF);
        // scheduling-table correctable only (bit 8)
        pulse('0, 32'h0000_0100, '0);
        rd(3'd3, 32'h1, "R6 correctable only");
        irqs(1'b0, 1'b0, "R8 disabled");
        wr(3'd5, 32'h1);
        irqs(1'b0, 1'b0, "R8 wrong memory enabled");
        wr(3'd5, 32'h4);
        rd(3'd5, 32'h4, "R8 enable readback");
        irqs(1'b1, 1'b0, "R8 enabled");
        rd(3'd1, 32'h0000_0100, "R8 status untouched");
        wr(3'd1, 32'h0000_0100);
        irqs(1'b0, 1'b0, "R8 cleared");

        // R3 DMA bank
        pulse('0, '0, 32'hFFFF_FFFF);
        rd(3'd2, 32'h7, "R3 dma mask");
        rd(3'd4, 32'h3, "R7 dma summary");
        irqs(1'b0, 1'b1, "R9 dma");
        wr(3'd2, 32'h6);
        rd(3'd2, 32'h1, "R3 correctable left");
        irqs(1'b0, 1'b0, "R8 dma disabled");
        wr(3'd6, 32'h1);
        rd(3'd6, 32'h1, "R8 dma enable readback");
        irqs(1'b1, 1'b0, "R8 dma enabled");
        wr(3'd2, 32'h1);

        // R5 pulse vs clear in same cycle (queue receive mismatch, bit 5)
        pulse('0, 32'h0000_0020, '0);
        mtl_err_i = 32'h0000_0020;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd1; req_wdata = 32'h0000_0020;
        @(negedge clk);
        mtl_err_i = '0; req_valid = 1'b0; req_write = 1'b0;
        rd(3'd1, 32'h0000_0020, "R5 pulse wins over clear");

        // R6 summary write ignored, R11 unmapped address
        wr(3'd3, 32'h0);
        rd(3'd3, 32'h2, "R6 write ignored");
        rd(3'd7, 32'h0, "R11 unmapped");

        repeat (3) @(negedge clk);
        chk("R11 pending reads", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule